// File: doc/BRIEF.md
# Oversampled Serial Receiver with Majority Voting

This block receives asynchronous serial characters from a single line that idles high. A baud tick arrives sixteen times per bit period. On each tick the receiver takes one sample of the resynchronised line. Every bit is decided from the middle of its period: samples 8, 9 and 10 are taken, and the value held by at least two of the three wins. The same vote decides whether a falling edge is a real start bit or only a glitch.

A finished character lands in a holding register that the host drains with a one-cycle read strobe. A receive-complete flag and a framing-error flag describe the byte that is waiting. If a character finishes while the holding register is still unread, that character is dropped. The loss is recorded internally and only appears on the overrun output when the host next reads the holding register. A mode input selects characters of 8 or 9 data bits.

Top module: `osrx_receiver`

## Requirements
- R1: Sample 1 of a start bit is the first tick on which the line reads low after reading high on the previous tick. If two or more of samples 8, 9 and 10 are high, the start is discarded, no character results, and the receiver waits for a new high-to-low transition.
- R2: Each bit period lasts 16 ticks. Data bits arrive least significant bit first, and each bit takes the majority value of its samples 8, 9 and 10, so a single disagreeing sample among them has no effect.
- R3: `frame_err_o` is 1 for a character whose stop-bit samples 8 to 10 are mostly low, and 0 for a character whose stop bit is mostly high. The flag is held together with the character it describes.
- R4: At the stop-bit vote, the received data is moved to `rx_data_o` and `rx_valid_o` goes to 1, whether or not the stop bit was good.
- R5: A read strobe while `rx_valid_o` is 1 clears `rx_valid_o`. While the holding register is unread, `rx_data_o` and `frame_err_o` do not change.
- R6: A character that completes while `rx_valid_o` is 1 and no read is happening is discarded, and an overrun is recorded. `overrun_o` changes only on a read of a valid character: it then takes the recorded value, and the record is cleared.
- R7: With `mode9_i` high when a start bit is accepted, the character has 9 data bits and the ninth appears on `rx_bit9_o`. With 8-bit characters, `rx_bit9_o` is 0.
- R8: While `en_i` is low, the line is ignored and no character is received.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_16x_i | input | 1 | One-cycle pulse, 16 per bit period |
| rx_i | input | 1 | Asynchronous serial line, idle high |
| en_i | input | 1 | Receiver enable |
| mode9_i | input | 1 | 1 selects 9 data bits per character |
| rd_i | input | 1 | Host read strobe for the holding register |
| rx_data_o | output | DATA_W | Received data, low 8 bits |
| rx_bit9_o | output | 1 | Ninth received data bit |
| rx_valid_o | output | 1 | Receive-complete flag |
| frame_err_o | output | 1 | Stop-bit error for the held character |
| overrun_o | output | 1 | Buffered overrun indication |

## Verification
The properties assume that `rd_i` is a single-cycle strobe and that the tick is a single-cycle pulse with several clocks between pulses. They also assume that each line value stays stable long enough to pass the two-flop synchroniser before the tick that samples it. The bench changes the line only at a falling clock edge, three clocks ahead of each tick. It raises the read strobe for exactly one clock and never reads while a character is being completed. The overrun and discard properties are therefore reached only through the intended paths.

// File: rtl/osrx_pkg.sv
package osrx_pkg;

   typedef enum logic [1:0] {
      RX_IDLE  = 2'd0,
      RX_START = 2'd1,
      RX_DATA  = 2'd2,
      RX_STOP  = 2'd3
   } rx_state_e;

   function automatic logic maj3(input logic a, input logic b, input logic c);
      return (a & b) | (a & c) | (b & c);
   endfunction

endpackage

// File: rtl/osrx_sync.sv
module osrx_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);
   logic [STAGES-1:0] chain_q;

   generate
      if (STAGES == 1) begin : g_single
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) chain_q <= '1;
            else        chain_q <= d_i;
      end else begin : g_multi
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) chain_q <= '1;
            else        chain_q <= {chain_q[STAGES-2:0], d_i};
      end
   endgenerate

   assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/osrx_vote.sv
module osrx_vote
   import osrx_pkg::*;
#(
   parameter int CNT_W      = 5,
   parameter int VOTE_FIRST = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_i,
   input  logic             active_i,
   input  logic [CNT_W-1:0] pos_i,
   input  logic             sample_i,
   output logic             ready_o,
   output logic             bit_o
);
   localparam logic [CNT_W-1:0] POS_A = CNT_W'(VOTE_FIRST);
   localparam logic [CNT_W-1:0] POS_B = CNT_W'(VOTE_FIRST + 1);
   localparam logic [CNT_W-1:0] POS_C = CNT_W'(VOTE_FIRST + 2);

   logic smp_a_q, smp_b_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         smp_a_q <= 1'b1;
         smp_b_q <= 1'b1;
      end else if (tick_i && active_i) begin
         if (pos_i == POS_A) smp_a_q <= sample_i;
         if (pos_i == POS_B) smp_b_q <= sample_i;
      end
   end

   assign ready_o = tick_i && active_i && (pos_i == POS_C);
   assign bit_o   = maj3(smp_a_q, smp_b_q, sample_i);
endmodule

// File: rtl/osrx_fsm.sv
module osrx_fsm
   import osrx_pkg::*;
#(
   parameter int OVERSAMPLE = 16,
   parameter int VOTE_FIRST = 8,
   parameter int DATA_W     = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            tick_i,
   input  logic            rx_s_i,
   input  logic            en_i,
   input  logic            mode9_i,
   output logic            done_o,
   output logic [DATA_W:0] char_o,
   output logic            fe_o
);
   localparam int NB    = DATA_W + 1;
   localparam int CNT_W = $clog2(OVERSAMPLE + 1);
   localparam int IDX_W = $clog2(NB);
   localparam logic [CNT_W-1:0] POS_LAST = CNT_W'(OVERSAMPLE);
   localparam logic [IDX_W-1:0] IDX_8    = IDX_W'(DATA_W - 1);
   localparam logic [IDX_W-1:0] IDX_9    = IDX_W'(DATA_W);

   rx_state_e        state_q;
   logic [CNT_W-1:0] cnt_q, pos;
   logic [IDX_W-1:0] idx_q;
   logic [NB-1:0]    shift_q;
   logic             m9_q, prev_q, done_q, fe_q;
   logic             vote_rdy, vote_bit;

   assign pos = cnt_q + CNT_W'(1);

   osrx_vote #(.CNT_W(CNT_W), .VOTE_FIRST(VOTE_FIRST)) u_vote (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick_i   (tick_i),
      .active_i (state_q != RX_IDLE),
      .pos_i    (pos),
      .sample_i (rx_s_i),
      .ready_o  (vote_rdy),
      .bit_o    (vote_bit)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= RX_IDLE;
         cnt_q   <= '0;
         idx_q   <= '0;
         shift_q <= '0;
         m9_q    <= 1'b0;
         prev_q  <= 1'b1;
         done_q  <= 1'b0;
         fe_q    <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (tick_i) prev_q <= rx_s_i;
         if (!en_i) begin
            state_q <= RX_IDLE;
         end else if (tick_i) begin
            unique case (state_q)
               RX_IDLE: begin
                  if (prev_q && !rx_s_i) begin
                     state_q <= RX_START;
                     cnt_q   <= CNT_W'(1);
                  end
               end
               RX_START: begin
                  cnt_q <= pos;
                  if (vote_rdy && vote_bit) begin
                     state_q <= RX_IDLE;
                  end else if (pos == POS_LAST) begin
                     cnt_q   <= '0;
                     idx_q   <= '0;
                     shift_q <= '0;
                     m9_q    <= mode9_i;
                     state_q <= RX_DATA;
                  end
               end
               RX_DATA: begin
                  cnt_q <= pos;
                  if (vote_rdy) shift_q[idx_q] <= vote_bit;
                  if (pos == POS_LAST) begin
                     cnt_q <= '0;
                     if (idx_q == (m9_q ? IDX_9 : IDX_8)) state_q <= RX_STOP;
                     else                               idx_q   <= idx_q + IDX_W'(1);
                  end
               end
               RX_STOP: begin
                  cnt_q <= pos;
                  if (vote_rdy) begin
                     fe_q    <= !vote_bit;
                     done_q  <= 1'b1;
                     state_q <= RX_IDLE;
                  end
               end
               default: state_q <= RX_IDLE;
            endcase
         end
      end
   end

   assign done_o = done_q;
   assign char_o = shift_q;
   assign fe_o   = fe_q;
endmodule

// File: rtl/osrx_hold.sv
module osrx_hold #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              done_i,
   input  logic [DATA_W:0]   char_i,
   input  logic              fe_i,
   input  logic              rd_i,
   output logic [DATA_W-1:0] data_o,
   output logic              bit9_o,
   output logic              valid_o,
   output logic              fe_o,
   output logic              ovr_o,
   output logic              ovr_pend_o
);
   logic [DATA_W-1:0] data_q;
   logic              bit9_q, valid_q, fe_q, ovr_q, pend_q;
   logic              rd_ok;

   assign rd_ok = rd_i && valid_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q  <= '0;
         bit9_q  <= 1'b0;
         valid_q <= 1'b0;
         fe_q    <= 1'b0;
         ovr_q   <= 1'b0;
         pend_q  <= 1'b0;
      end else begin
         if (rd_ok) begin
            valid_q <= 1'b0;
            ovr_q   <= pend_q;
            pend_q  <= 1'b0;
         end
         if (done_i) begin
            if (valid_q && !rd_ok) begin
               pend_q <= 1'b1;
            end else begin
               data_q  <= char_i[DATA_W-1:0];
               bit9_q  <= char_i[DATA_W];
               fe_q    <= fe_i;
               valid_q <= 1'b1;
            end
         end
      end
   end

   assign data_o     = data_q;
   assign bit9_o     = bit9_q;
   assign valid_o    = valid_q;
   assign fe_o       = fe_q;
   assign ovr_o      = ovr_q;
   assign ovr_pend_o = pend_q;
endmodule

// File: rtl/osrx_receiver.sv
module osrx_receiver #(
   parameter int OVERSAMPLE  = 16,
   parameter int VOTE_FIRST  = 8,
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_16x_i,
   input  logic              rx_i,
   input  logic              en_i,
   input  logic              mode9_i,
   input  logic              rd_i,
   output logic [DATA_W-1:0] rx_data_o,
   output logic              rx_bit9_o,
   output logic              rx_valid_o,
   output logic              frame_err_o,
   output logic              overrun_o
);
   generate
      if (OVERSAMPLE < VOTE_FIRST + 3) begin : g_bad_vote
         $error("vote window must end before the last oversample");
      end
      if (VOTE_FIRST < 2) begin : g_bad_first
         $error("vote window must start after the edge sample");
      end
      if (DATA_W < 1) begin : g_bad_width
         $error("DATA_W must be at least 1");
      end
      if (SYNC_STAGES < 1) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 1");
      end
   endgenerate

   logic            rx_s;
   logic            char_done;
   logic [DATA_W:0] char_bits;
   logic            char_fe;
   logic            ovr_pend;

   osrx_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (rx_i),
      .q_o   (rx_s)
   );

   osrx_fsm #(
      .OVERSAMPLE (OVERSAMPLE),
      .VOTE_FIRST (VOTE_FIRST),
      .DATA_W     (DATA_W)
   ) u_fsm (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick_i  (tick_16x_i),
      .rx_s_i  (rx_s),
      .en_i    (en_i),
      .mode9_i (mode9_i),
      .done_o  (char_done),
      .char_o  (char_bits),
      .fe_o    (char_fe)
   );

   osrx_hold #(.DATA_W(DATA_W)) u_hold (
      .clk        (clk),
      .rst_n      (rst_n),
      .done_i     (char_done),
      .char_i     (char_bits),
      .fe_i       (char_fe),
      .rd_i       (rd_i),
      .data_o     (rx_data_o),
      .bit9_o     (rx_bit9_o),
      .valid_o    (rx_valid_o),
      .fe_o       (frame_err_o),
      .ovr_o      (overrun_o),
      .ovr_pend_o (ovr_pend)
   );
endmodule

// File: rtl/osrx_checker.sv
module osrx_checker #(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              en_i,
   input logic              rd_i,
   input logic              char_done,
   input logic              ovr_pend,
   input logic              rx_valid_o,
   input logic [DATA_W-1:0] rx_data_o,
   input logic              frame_err_o,
   input logic              overrun_o
);
   p_done_sets_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
      char_done |=> rx_valid_o);

   p_read_clears_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_i && rx_valid_o && !char_done) |=> !rx_valid_o);

   p_data_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid_o && !rd_i) |=> $stable(rx_data_o));

   p_fe_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid_o && !rd_i) |=> $stable(frame_err_o));

   p_overrun_buffered_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !(rd_i && rx_valid_o) |=> $stable(overrun_o));

   p_overrun_recorded_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (char_done && rx_valid_o && !rd_i) |=> ovr_pend);

   p_disabled_silent_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !en_i |=> !char_done);
endmodule

bind osrx_receiver osrx_checker #(.DATA_W(DATA_W)) u_osrx_checker (
   .clk         (clk),
   .rst_n       (rst_n),
   .en_i        (en_i),
   .rd_i        (rd_i),
   .char_done   (char_done),
   .ovr_pend    (ovr_pend),
   .rx_valid_o  (rx_valid_o),
   .rx_data_o   (rx_data_o),
   .frame_err_o (frame_err_o),
   .overrun_o   (overrun_o)
);

// File: tb/osrx_receiver_test.sv
`timescale 1ns/1ps
module osrx_receiver_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick = 1'b0;
   logic       rx = 1'b1;
   logic       en = 1'b1;
   logic       mode9 = 1'b0;
   logic       rd = 1'b0;
   logic [7:0] rx_data;
   logic       rx_bit9, rx_valid, frame_err, overrun;

   int checks = 0;
   int fails  = 0;
   int cycles = 0;
   bit ended  = 1'b0;

   always #2 clk = ~clk;

   osrx_receiver uut (
      .clk         (clk),
      .rst_n       (rst_n),
      .tick_16x_i  (tick),
      .rx_i        (rx),
      .en_i        (en),
      .mode9_i     (mode9),
      .rd_i        (rd),
      .rx_data_o   (rx_data),
      .rx_bit9_o   (rx_bit9),
      .rx_valid_o  (rx_valid),
      .frame_err_o (frame_err),
      .overrun_o   (overrun)
   );

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic sample(input logic v);
      @(negedge clk) rx = v;
      @(negedge clk);
      @(negedge clk) tick = 1'b1;
      @(negedge clk) tick = 1'b0;
   endtask

   task automatic samples(input logic v, input int n);
      for (int i = 0; i < n; i++) sample(v);
   endtask

   // one bit period; glitch inverts sample 9 only
   task automatic bit_period(input logic v, input bit glitch);
      for (int s = 1; s <= 16; s++) sample((glitch && s == 9) ? ~v : v);
   endtask

   task automatic send_frame(input logic [8:0] val, input int nbits,
                             input logic stop_v, input bit glitch);
      samples(1'b1, 4);
      bit_period(1'b0, glitch);
      for (int b = 0; b < nbits; b++) bit_period(val[b], glitch);
      bit_period(stop_v, glitch);
      samples(1'b1, 4);
   endtask

   task automatic host_read();
      @(negedge clk) rd = 1'b1;
      @(negedge clk) rd = 1'b0;
      @(negedge clk);
   endtask

   task automatic t_reset();
      check("R4 reset valid", rx_valid, 0);
      check("R3 reset frame_err", frame_err, 0);
      check("R6 reset overrun", overrun, 0);
   endtask

   task automatic t_basic();
      send_frame(9'h0A5, 8, 1'b1, 1'b0);
      check("R4 valid after char", rx_valid, 1);
      check("R2 data lsb first", rx_data, 8'hA5);
      check("R3 good stop", frame_err, 0);
      check("R7 bit9 zero in 8-bit", rx_bit9, 0);
      host_read();
      check("R5 read clears valid", rx_valid, 0);
   endtask

   task automatic t_noise();
      samples(1'b1, 4);
      samples(1'b0, 7);
      samples(1'b1, 30);
      check("R1 spike of 7 rejected", rx_valid, 0);
      samples(1'b0, 8);
      samples(1'b1, 30);
      check("R1 spike of 8 rejected", rx_valid, 0);
      send_frame(9'h03C, 8, 1'b1, 1'b0);
      check("R1 receive after spikes", rx_valid, 1);
      check("R1 data after spikes", rx_data, 8'h3C);
      host_read();
   endtask

   task automatic t_glitch();
      send_frame(9'h069, 8, 1'b1, 1'b1);
      check("R2 one bad sample outvoted valid", rx_valid, 1);
      check("R2 one bad sample outvoted data", rx_data, 8'h69);
      check("R3 stop with one bad sample", frame_err, 0);
      host_read();
   endtask

   task automatic t_frame_err();
      send_frame(9'h0C3, 8, 1'b0, 1'b0);
      check("R4 valid despite bad stop", rx_valid, 1);
      check("R4 data despite bad stop", rx_data, 8'hC3);
      check("R3 frame error set", frame_err, 1);
      host_read();
      send_frame(9'h011, 8, 1'b1, 1'b0);
      check("R3 frame error clears on good char", frame_err, 0);
      check("R3 data after recovery", rx_data, 8'h11);
      host_read();
   endtask

   task automatic t_overrun();
      send_frame(9'h0AA, 8, 1'b1, 1'b0);
      send_frame(9'h055, 8, 1'b1, 1'b0);
      check("R6 held byte kept", rx_data, 8'hAA);
      check("R6 overrun hidden before read", overrun, 0);
      host_read();
      check("R6 overrun shown on read", overrun, 1);
      check("R5 valid cleared after overrun read", rx_valid, 0);
      send_frame(9'h077, 8, 1'b1, 1'b0);
      check("R6 new byte after overrun", rx_data, 8'h77);
      check("R6 overrun held until read", overrun, 1);
      host_read();
      check("R6 overrun clears on clean read", overrun, 0);
   endtask

   task automatic t_nine();
      mode9 = 1'b1;
      send_frame(9'h13C, 9, 1'b1, 1'b0);
      check("R7 low data in 9-bit", rx_data, 8'h3C);
      check("R7 ninth bit one", rx_bit9, 1);
      check("R7 stop ok in 9-bit", frame_err, 0);
      host_read();
      send_frame(9'h0F0, 9, 1'b1, 1'b0);
      check("R7 ninth bit zero", rx_bit9, 0);
      check("R7 data second 9-bit", rx_data, 8'hF0);
      host_read();
      mode9 = 1'b0;
      send_frame(9'h081, 8, 1'b1, 1'b0);
      check("R7 back to 8-bit data", rx_data, 8'h81);
      host_read();
   endtask

   task automatic t_disabled();
      en = 1'b0;
      send_frame(9'h0E7, 8, 1'b1, 1'b0);
      check("R8 nothing received while disabled", rx_valid, 0);
      check("R8 data unchanged while disabled", rx_data, 8'h81);
      en = 1'b1;
      send_frame(9'h042, 8, 1'b1, 1'b0);
      check("R8 receives after enable", rx_data, 8'h42);
      host_read();
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000 && !ended) begin
         ended = 1'b1;
         fails++;
         checks++;
         $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_reset();
      t_basic();
      t_noise();
      t_glitch();
      t_frame_err();
      t_overrun();
      t_nine();
      t_disabled();
      if (!ended) begin
         ended = 1'b1;
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end
endmodule